// File: doc/BRIEF.md
# Sequenced Second-Order Recursive Filter Section

This block filters a stream of signed 16-bit samples through one second-order recursive section arranged in Direct Form II. Each accepted sample first builds the intermediate state value from the input and the two stored state values through the feedback coefficients. The output sample is then formed from that new state and the same two stored values through the feedforward coefficients.

All arithmetic goes through one signed 16x16 multiplier and one 32-bit add/subtract unit. A small phase counter steps them through five multiply-accumulate operations and then one store-and-output cycle. The five coefficients are static inputs in signed Q2.14 format. Results are scaled back and saturated to 16 bits at two points: before the new state is stored, and before the output is presented. A producer pulses `in_valid` with a sample whenever `busy` is low. It collects the result on the single-cycle `out_valid` pulse.

Top module: `biquad_df2_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears both stored state values, the accumulator and `out_sample` to zero, and drives `busy` and `out_valid` low.
- R2: The new state is w = sat16(floor(A / 2^14)). Here A is built in a 32-bit accumulator in this order: x·2^14, then minus a1·w1, then minus a2·w2. w1 and w2 are the previous and second previous state values.
- R3: The output is y = sat16(floor(B / 2^14)). B is built in this order: b1·w1, then plus b2·w2, then plus b0·w. It uses the same w1 and w2 as R2.
- R4: Coefficients are signed Q2.14 (16384 means 1.0). The downscaling by 2^14 is an arithmetic right shift, so it rounds toward minus infinity.
- R5: A scaled state value outside [-32768, 32767] is stored clamped to the nearer limit.
- R6: A scaled output value outside [-32768, 32767] is presented clamped to the nearer limit.
- R7: Every add or subtract in the accumulator saturates at the signed 32-bit limits and does not wrap.
- R8: After each sample, w1 takes the new state and w2 takes the old w1. Later samples see this shifted history.
- R9: `in_valid` sampled high while `busy` is low starts a sample. `busy` is then high for exactly 6 cycles. At the edge that ends them, `out_sample` updates, `out_valid` is high for one cycle and `busy` is low.
- R10: `in_valid` while `busy` is high is ignored. It does not change the current result or the stored state.
- R11: `out_sample` holds its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 16 | Signed input sample x |
| coef_b0 | input | 16 | Feedforward coefficient on w, Q2.14 |
| coef_b1 | input | 16 | Feedforward coefficient on w1, Q2.14 |
| coef_b2 | input | 16 | Feedforward coefficient on w2, Q2.14 |
| coef_a1 | input | 16 | Feedback coefficient on w1, Q2.14 |
| coef_a2 | input | 16 | Feedback coefficient on w2, Q2.14 |
| busy | output | 1 | High while a sample is being processed |
| out_valid | output | 1 | One-cycle pulse when out_sample is new |
| out_sample | output | 16 | Signed output sample y |

## Verification
A pass-through coefficient set with a coarse sweep over the whole input range isolates the input scaling and the output path from any feedback. A pure delay setting shows whether the history shifts in the right order. A set with a negative fractional feedback coefficient exposes flooring and the sign of the subtractions. Long runs with pseudo-random coefficients and inputs, including full-scale values, drive the state and output clamps and the 32-bit accumulator limits. These are compared against a bench model that applies the same saturation order. A variant that keeps the strobe high with a different sample throughout each computation shows that strobes arriving while busy leave both the result and the history untouched.

// File: rtl/biquad_df2_seq.sv
module biquad_df2_seq #(
  parameter int DW   = 16,
  parameter int FRAC = 14,
  parameter int AW   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  input  logic signed [DW-1:0] coef_b0,
  input  logic signed [DW-1:0] coef_b1,
  input  logic signed [DW-1:0] coef_b2,
  input  logic signed [DW-1:0] coef_a1,
  input  logic signed [DW-1:0] coef_a2,
  output logic                 busy,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_sample
);
  localparam int PW = 2 * DW;
  localparam logic [2:0] LAST = 3'd6;
  localparam logic signed [AW-1:0] QMAX = AW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [AW-1:0] QMIN = -QMAX - 1;

  logic [2:0]                ph;
  logic signed [DW-1:0]      w1, w2, wn;
  logic signed [AW-1:0]      acc, acc_next;
  logic signed [DW-1:0]      mc, md;
  logic                      sub, clr;
  logic signed [PW-1:0]      prod;
  logic signed [AW:0]        sum;

  function automatic logic signed [DW-1:0] scale_sat(input logic signed [AW-1:0] v);
    logic signed [AW-1:0] s;
    s = v >>> FRAC;
    if (s > QMAX)      scale_sat = QMAX[DW-1:0];
    else if (s < QMIN) scale_sat = QMIN[DW-1:0];
    else               scale_sat = s[DW-1:0];
  endfunction

  always_comb begin
    mc = '0; md = '0; sub = 1'b0; clr = 1'b0;
    case (ph)
      3'd1: begin mc = coef_a1; md = w1; sub = 1'b1; end
      3'd2: begin mc = coef_a2; md = w2; sub = 1'b1; end
      3'd3: begin mc = coef_b1; md = w1; clr = 1'b1; end
      3'd4: begin mc = coef_b2; md = w2; end
      3'd5: begin mc = coef_b0; md = wn; end
      default: ;
    endcase
  end

  assign prod = mc * md;
  assign sum  = sub ? ((clr ? (AW+1)'(0) : (AW+1)'(acc)) - (AW+1)'(prod))
                    : ((clr ? (AW+1)'(0) : (AW+1)'(acc)) + (AW+1)'(prod));
  assign acc_next = (sum[AW] != sum[AW-1]) ? {sum[AW], {(AW-1){~sum[AW]}}} : sum[AW-1:0];
  assign busy = (ph != 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0; acc <= '0; w1 <= '0; w2 <= '0; wn <= '0;
      out_valid <= 1'b0; out_sample <= '0;
    end else begin
      out_valid <= 1'b0;
      if (ph == 3'd0) begin
        if (in_valid) begin
          acc <= AW'(in_sample) <<< FRAC;
          ph  <= 3'd1;
        end
      end else if (ph == LAST) begin
        out_sample <= scale_sat(acc);
        w2 <= w1;
        w1 <= wn;
        out_valid <= 1'b1;
        ph <= 3'd0;
      end else begin
        acc <= acc_next;
        if (ph == 3'd3) wn <= scale_sat(acc);
        ph <= ph + 3'd1;
      end
    end
  end
endmodule

module biquad_df2_seq_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 busy,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_sample
);
  logic [3:0] run;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0; warm <= 1'b0;
    end else begin
      warm <= 1'b1;
      run  <= busy ? run + 4'd1 : 4'd0;
    end
  end

  a_r9_start: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !busy) |=> busy);
  a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
  a_r9_done: assert property (@(posedge clk) disable iff (rst)
    (warm && out_valid) |-> (!busy && $past(busy)));
  a_r9_len: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run < 4'd6));
  a_r9_end: assert property (@(posedge clk) disable iff (rst)
    (warm && $fell(busy)) |-> out_valid);
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (warm && !out_valid) |-> $stable(out_sample));
endmodule

bind biquad_df2_seq biquad_df2_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .busy(busy),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/biquad_df2_seq_tb.sv
module biquad_df2_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic signed [15:0] b0 = '0, b1 = '0, b2 = '0, a1 = '0, a2 = '0;
  logic busy, out_valid;
  logic signed [15:0] out_sample;

  int checks = 0, errors = 0;
  longint mw1 = 0, mw2 = 0;
  int unsigned seed = 32'h1234_5678;
  bit done = 1'b0;

  always #4 clk = ~clk;

  biquad_df2_seq u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .coef_b0(b0), .coef_b1(b1), .coef_b2(b2), .coef_a1(a1), .coef_a2(a2),
    .busy(busy), .out_valid(out_valid), .out_sample(out_sample)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint sat(input longint v, input longint lim);
    if (v > lim - 1) return lim - 1;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic longint a32(input longint v);
    return sat(v, 64'sd2147483648);
  endfunction

  function automatic longint model(input longint x);
    longint acc, w, y;
    acc = x * 16384;
    acc = a32(acc - longint'(a1) * mw1);
    acc = a32(acc - longint'(a2) * mw2);
    w   = sat(acc >>> 14, 32768);
    acc = longint'(b1) * mw1;
    acc = a32(acc + longint'(b2) * mw2);
    acc = a32(acc + longint'(b0) * w);
    y   = sat(acc >>> 14, 32768);
    mw2 = mw1;
    mw1 = w;
    return y;
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    mw1 = 0; mw2 = 0;
  endtask

  task automatic send(input logic signed [15:0] x, input bit spam, input string req);
    longint exp;
    int n;
    bit seen;
    exp = model(longint'(x));
    @(negedge clk);
    in_valid = 1'b1; in_sample = x;
    n = 0; seen = 1'b0;
    for (int i = 0; i < 12 && !seen; i++) begin
      @(negedge clk);
      if (spam) in_sample = ~x; else in_valid = 1'b0;
      if (out_valid) begin
        seen = 1'b1;
        in_valid = 1'b0;
      end else begin
        n++;
        if (!busy) chk(1'b0, "R9 busy during compute", 0, 1);
      end
    end
    chk(seen && n == 6, "R9 latency", n, 6);
    chk(!busy, "R9 busy low on pulse", busy, 0);
    chk(out_sample == exp, req, out_sample, exp);
    @(negedge clk);
    chk(!out_valid, "R9 single pulse", out_valid, 0);
    chk(out_sample == exp, "R11 hold", out_sample, exp);
  endtask

  initial begin
    do_reset();
    chk(!busy && !out_valid && out_sample == 0, "R1 reset outputs", out_sample, 0);

    b0 = 16'sd16384;
    for (int v = -32768; v < 32768; v += 257) send(16'(v), 1'b0, "R2 R3 R4 pass-through sweep");
    send(16'sd32767, 1'b0, "R4 pass-through max");
    send(-16'sd32768, 1'b0, "R4 pass-through min");

    do_reset();
    chk(out_sample == 0, "R1 reset clears output", out_sample, 0);
    b0 = 0; b2 = 16'sd16384;
    send(16'sd1000, 1'b0, "R1 R8 delay first");
    send(16'sd2000, 1'b0, "R8 delay second");
    send(16'sd3000, 1'b0, "R8 delay yields x(n-2)");
    chk(out_sample == 1000, "R8 history order", out_sample, 1000);

    do_reset();
    b0 = 16'sd16384; b1 = 0; b2 = 0; a1 = -16'sd8193; a2 = 16'sd5;
    for (int i = 0; i < 20; i++) send(16'((i % 3 == 0) ? -777 : 15), 1'b0, "R2 R4 feedback floor");

    do_reset();
    b0 = 16'sd32767; b1 = 16'sd32767; b2 = 16'sd32767; a1 = -16'sd32768; a2 = -16'sd32768;
    for (int i = 0; i < 30; i++) send(16'sd32767, 1'b0, "R5 R6 R7 saturation");
    b0 = -16'sd32768; b1 = -16'sd32768; b2 = -16'sd32768;
    for (int i = 0; i < 10; i++) send(-16'sd32768, 1'b0, "R5 R6 R7 negative saturation");

    do_reset();
    b0 = 16'sd16384; b1 = 16'sd8192; b2 = -16'sd4096; a1 = -16'sd12000; a2 = 16'sd6000;
    for (int i = 0; i < 40; i++) send(16'(rnd() >> 16), (i % 2) == 1, "R10 busy strobes ignored");

    for (int k = 0; k < 40; k++) begin
      do_reset();
      b0 = 16'(rnd() >> 8); b1 = 16'(rnd() >> 8); b2 = 16'(rnd() >> 8);
      a1 = 16'(rnd() >> 8); a2 = 16'(rnd() >> 8);
      for (int i = 0; i < 50; i++) send(16'(rnd() >> 12), (i % 5) == 0, "R2 R3 R7 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule